// File: doc/BRIEF.md
# Byte-Lane Aligned Access Splitter

This block sits between a processor load/store port and a memory bus that is built from parallel byte-wide banks. Each request names a size (one, two or four bytes) and any byte address. The block turns it into bus cycles that always use an aligned bus-word address. A per-bank enable vector selects the lanes that carry the operand.

An operand that fits inside one aligned bus word takes one bus cycle. An operand that straddles a bus-word boundary takes two bus cycles. The lower-address word is accessed first and the next word second. On reads, the lanes returned by the two cycles are joined, shifted down by the address offset and zero-filled above the operand, which gives a right-justified little-endian value. On writes, each data byte is steered onto the lane that matches its address.

The controller has three states:
- `ST_IDLE` accepts a request.
- `ST_LOW` drives the lower (or only) bus cycle.
- `ST_HIGH` drives the upper cycle of a split access.

It has four transitions:
- IDLE to LOW when a request is accepted.
- LOW to IDLE on acknowledge when the operand does not cross a boundary.
- LOW to HIGH on acknowledge when it does cross.
- HIGH to IDLE on acknowledge.

Top module: `lane_splitter`

## Requirements
- R1: After reset, req_ready is 1, bus_req is 0 and rsp_valid is 0.
- R2: The size code req_size gives the byte count: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. An operand whose offset (address bits [1:0]) plus byte count is at most 4 uses exactly one bus cycle. That cycle's bus_addr equals the request address with bits [1:0] cleared.
- R3: An operand whose offset plus byte count exceeds 4 uses exactly two bus cycles. The first is at the aligned word holding the operand address. The second is at that address plus 4.
- R4: A read returns rsp_rdata whose byte i (bits 8i+7..8i) equals the memory byte at request address + i. All bytes at or above the byte count read as zero.
- R5: A write stores byte i of req_wdata into the memory byte at address + i, for every i below the byte count. No other memory byte changes.
- R6: bus_be bit k enables bank k, which holds the byte at aligned address + k. In the first cycle, bus_be has ones for lanes offset to min(offset+count, 4)-1. A single-byte access at any offset, odd ones included, enables exactly lane offset.
- R7: req_ready is 0 from the cycle after a request is accepted until the final bus acknowledge. rsp_valid is a one-cycle pulse in the cycle after that final acknowledge.
- R8: While bus_req is 1 and bus_ack is 0, bus_addr, bus_be, bus_we and bus_wdata hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Size code (0:1, 1:2, 2/3:4 bytes) |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | DATA_W | Store data, right-justified |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | DATA_W | Load result, right-justified, zero-filled |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Aligned bus-word address |
| bus_be | output | DATA_W/8 | Bank enable strobes |
| bus_wdata | output | DATA_W | Lane-steered write data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | DATA_W | Bus read data, all lanes |

## Verification
Each wrong internal state shows at a specific point on the ports:
- A mis-decoded crossing test shows at once as a missing or extra second bus cycle. It is caught in the same operation, through the acknowledge count and the second address.
- A wrong offset in the lane map shows in the first cycle's bank enables.
- A wrong offset in the merge shows in rsp_rdata one cycle after the last acknowledge.
- Lost steering of write data is caught later. It appears when the bench compares its memory image with the expected one, and in the read-backs that follow.
- A state register stuck out of idle shows as req_ready held low, which the watchdog catches.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } lsplit_state_e;
endpackage

// File: rtl/lsplit_lane_map.sv
module lsplit_lane_map #(
    parameter int NB    = 4,
    parameter int OFF_W = $clog2(NB)
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output logic [NB-1:0]    keep,
    output logic [2*NB-1:0]  mask2,
    output logic             crosses
);
    int nbytes;

    always_comb begin
        if (int'(size) > OFF_W) nbytes = 1 << OFF_W;
        else                    nbytes = 1 << size;
        for (int i = 0; i < NB; i++) keep[i] = (i < nbytes);
    end

    assign mask2   = {{NB{1'b0}}, keep} << off;
    assign crosses = |mask2[2*NB-1:NB];
endmodule

// File: rtl/lsplit_wr_steer.sv
module lsplit_wr_steer #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input  logic [OFF_W-1:0]    off,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] lanes2
);
    assign lanes2 = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
endmodule

// File: rtl/lsplit_rd_merge.sv
module lsplit_rd_merge #(
    parameter int DATA_W = 32,
    parameter int NB     = DATA_W / 8,
    parameter int OFF_W  = $clog2(NB)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [NB-1:0]     keep,
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    output logic [DATA_W-1:0] result
);
    logic [2*DATA_W-1:0] joined;

    assign joined = {hi_word, lo_word} >> {off, 3'b000};

    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign result[8*b +: 8] = keep[b] ? joined[8*b +: 8] : 8'h00;
        end
    endgenerate
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
    import lsplit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W/8-1:0] bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    lsplit_state_e st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] lo_q;

    logic [NB-1:0]       keep;
    logic [2*NB-1:0]     mask2;
    logic                crosses;
    logic [2*DATA_W-1:0] lanes2;
    logic [DATA_W-1:0]   merge_lo, merge_hi, merged;
    logic [ADDR_W-1:0]   base_addr;
    logic                accept, last_ack;

    lsplit_lane_map #(.NB(NB), .OFF_W(OFF_W)) i_map (
        .off(addr_q[OFF_W-1:0]), .size(size_q),
        .keep(keep), .mask2(mask2), .crosses(crosses)
    );

    lsplit_wr_steer #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_steer (
        .off(addr_q[OFF_W-1:0]), .wdata(wdata_q), .lanes2(lanes2)
    );

    lsplit_rd_merge #(.DATA_W(DATA_W), .NB(NB), .OFF_W(OFF_W)) i_merge (
        .off(addr_q[OFF_W-1:0]), .keep(keep),
        .lo_word(merge_lo), .hi_word(merge_hi), .result(merged)
    );

    assign base_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        req_ready = 1'b0;
        bus_req   = 1'b0;
        bus_we    = we_q;
        bus_addr  = base_addr;
        bus_be    = mask2[NB-1:0];
        bus_wdata = lanes2[DATA_W-1:0];
        merge_lo  = bus_rdata;
        merge_hi  = '0;
        accept    = 1'b0;
        last_ack  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept = 1'b1;
                    st_d   = ST_LOW;
                end
            end
            ST_LOW: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    if (crosses) st_d = ST_HIGH;
                    else begin
                        st_d     = ST_IDLE;
                        last_ack = 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                bus_req   = 1'b1;
                bus_addr  = base_addr + ADDR_W'(NB);
                bus_be    = mask2[2*NB-1:NB];
                bus_wdata = lanes2[2*DATA_W-1:DATA_W];
                merge_lo  = lo_q;
                merge_hi  = bus_rdata;
                if (bus_ack) begin
                    st_d     = ST_IDLE;
                    last_ack = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            addr_q    <= '0;
            size_q    <= '0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
            lo_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            st_q      <= st_d;
            rsp_valid <= last_ack;
            if (accept) begin
                addr_q  <= req_addr;
                size_q  <= req_size;
                we_q    <= req_write;
                wdata_q <= req_wdata;
            end
            if (st_q == ST_LOW && bus_ack) lo_q <= bus_rdata;
            if (last_ack) rsp_rdata <= we_q ? '0 : merged;
        end
    end

    // checks beside the logic
    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_we) && $stable(bus_wdata)));
    assert_aligned_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[OFF_W-1:0] == '0 && bus_be != '0));
    assert_second_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_req && bus_ack) && bus_req) |-> (bus_addr == $past(bus_addr) + ADDR_W'(NB)));
endmodule

// File: tb/test_lane_splitter.sv
module test_lane_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int total = 0, bad = 0;

    typedef struct {
        logic        we;
        logic [31:0] rd;
        int          cyc;
        logic [31:0] addr0;
        logic [3:0]  be0;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [7:0] mem [64];
    logic [7:0] ref_mem [64];
    int  ack_cnt = 0;
    logic [31:0] seen_addr0;
    logic [3:0]  seen_be0;
    logic slow = 1'b0, waited = 1'b0;
    logic [31:0] sv_addr, sv_wdata;
    logic [3:0]  sv_be;

    always #5 clk = ~clk;

    lane_splitter i_lane_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus responder: memory model, optional one-cycle wait
    always @(negedge clk) begin
        if (!rst_n) bus_ack = 1'b0;
        else if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            if (slow && !waited) begin
                waited = 1'b1;
                sv_addr = bus_addr; sv_be = bus_be; sv_wdata = bus_wdata;
            end else begin
                if (waited) begin
                    check("R8 addr held", bus_addr, sv_addr);
                    check("R8 be/wdata held", {28'd0, bus_be} ^ (bus_wdata ^ sv_wdata),
                          {28'd0, sv_be});
                end
                waited = 1'b0;
                if (ack_cnt == 0) begin seen_addr0 = bus_addr; seen_be0 = bus_be; end
                ack_cnt++;
                for (int b = 0; b < 4; b++) begin
                    bus_rdata[8*b +: 8] = mem[{bus_addr[5:2], 2'(b)}];
                    if (bus_we && bus_be[b]) mem[{bus_addr[5:2], 2'(b)}] = bus_wdata[8*b +: 8];
                end
                bus_ack = 1'b1;
            end
        end
    end

    // monitor: pop expected item on each completion
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) check("R7 unexpected rsp", 32'd1, 32'd0);
            else begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, (e.cyc == 2) ? " R3 cycles" : " R2 cycles"}, ack_cnt, e.cyc);
                check({e.tag, " R2/R3 first addr"}, seen_addr0, e.addr0);
                check({e.tag, " R6 first be"}, {28'd0, seen_be0}, {28'd0, e.be0});
                if (!e.we) check({e.tag, " R4 rdata"}, rsp_rdata, e.rd);
            end
            ack_cnt = 0;
        end
    end

    task automatic do_op(input logic we, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] wd);
        exp_t e;
        int nb, off;
        logic [7:0] km;
        nb  = (sz >= 2) ? 4 : (1 << sz);
        off = int'(a[1:0]);
        km  = 8'((1 << nb) - 1) << off;
        e.we = we; e.rd = '0; e.cyc = (off + nb > 4) ? 2 : 1;
        e.addr0 = {a[31:2], 2'b00}; e.be0 = km[3:0];
        e.tag = $sformatf("%s sz%0d @%0d", we ? "wr" : "rd", sz, a);
        for (int i = 0; i < nb; i++) begin
            if (we) ref_mem[(a + i) & 63] = wd[8*i +: 8];
            else    e.rd[8*i +: 8] = ref_mem[(a + i) & 63];
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        q.push_back(e);
        req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 ready low after accept", {31'd0, req_ready}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (2) @(negedge clk);
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 bus_req", {31'd0, bus_req}, 32'd0);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // reads of every size at every offset: R2 R3 R4 R6
        for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++)
                do_op(1'b0, 2'(s), 32'(8 + o), '0);
        do_op(1'b0, 2'd3, 32'd13, '0);   // code 3 as 4 bytes, crossing
        // writes: R5
        do_op(1'b1, 2'd0, 32'd21, 32'hFFFF_FFA5);  // odd lane byte, R6
        do_op(1'b1, 2'd1, 32'd27, 32'hEEEE_C3D4);  // halfword crossing
        do_op(1'b1, 2'd2, 32'd33, 32'h1122_3344);  // word crossing
        do_op(1'b1, 2'd2, 32'd40, 32'hCAFE_F00D);  // aligned word
        do_op(1'b1, 2'd2, 32'd62, 32'hA1B2_C3D4);  // wraps bus word index
        slow = 1'b1;
        do_op(1'b0, 2'd2, 32'd19, '0);
        do_op(1'b0, 2'd1, 32'd27, '0);
        do_op(1'b0, 2'd2, 32'd33, '0);
        do_op(1'b1, 2'd1, 32'd45, 32'h0000_7788);
        do_op(1'b0, 2'd2, 32'd62, '0);
        do_op(1'b0, 2'd0, 32'd45, '0);
        do_op(1'b0, 2'd0, 32'd46, '0);
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 64; i++)
            check($sformatf("R5 mem[%0d]", i), {24'd0, mem[i]}, {24'd0, ref_mem[i]});
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule